// File: doc/BRIEF.md
# Instruction Length and Operand Decoder

This block takes one 16-bit instruction word together with the two memory words that follow it. It splits the word into a 5-bit opcode, a 5-bit destination-side operand selector (b) and a 6-bit source-side operand selector (a). It then assigns each operand an addressing-mode code and works out how many words the instruction occupies. It also routes each following word to the operand that owns it, and turns the compact in-word literals of the a operand into full 16-bit values. All decode results are registered and appear one clock after the words are presented.

The same block holds a skip sequencer. An execute stage uses it when a conditional instruction fails and the next instruction must be passed over. After a skip request, the sequencer consumes one instruction per clock from the word inputs, and the surrounding logic feeds those inputs from the address given by the sequencer's running word offset. When a consumed instruction is itself a conditional, the sequencer also passes over the instruction after it. When the sequencer stops, it reports the total number of words skipped and the number of cycles spent, one per skipped instruction.

Top module: `insn_len_decode`

## Requirements
- R1: One clock after `word0_i` is presented, `opcode_o` holds bits 4:0 of that word, `sel_b_o` holds bits 9:5 and `sel_a_o` holds bits 15:10.
- R2: Operand codes 0x00-0x07 give mode 0 (register), 0x08-0x0f give mode 1 (register indirect) and 0x10-0x17 give mode 2 (register plus following word, indirect).
- R3: Code 0x18 gives mode 3 (push) for b and mode 4 (pop) for a. Code 0x19 gives mode 5 (stack top) and 0x1a gives mode 6 (stack plus offset). Mode 6 takes no extra word.
- R4: Codes 0x1b, 0x1c and 0x1d give modes 7, 8 and 9 (stack pointer, program counter, overflow register). Code 0x1e gives mode 10 (following word, indirect) and 0x1f gives mode 11 (following word as literal).
- R5: An a code of 0x20-0x3f gives mode 12, with `lit_vld_o`=1 and `lit_o` = (code & 0x1f) - 1 modulo 65536, so 0x20 gives 0xffff and 0x3f gives 0x001e. For every other code, `lit_vld_o`=0 and `lit_o`=0.
- R6: `len_o` = 1 + the number of operands whose mode is 2, 10 or 11, which gives a value from 1 to 3.
- R7: The b operand's extra word is `word1_i` and appears on `ext_b_o`. The a operand's extra word is `word1_i` when b takes none and `word2_i` when b takes one, and appears on `ext_a_o`. An output whose operand takes no extra word reads 0.
- R8: When the opcode is 0, b is a sub-opcode: `mode_b_o` = 13 and b takes no extra word.
- R9: A `skip_req_i` seen while idle raises `skip_busy_o` on the next clock with `skip_words_o` and `skip_cycles_o` cleared. On each clock while busy, the sequencer consumes the instruction on the word inputs, adds its length to `skip_words_o` and adds 1 to `skip_cycles_o`.
- R10: The sequencer stays busy while the instruction it consumed has an opcode in 0x10-0x17. After it consumes any other opcode, `skip_busy_o` falls, `skip_done_o` pulses for one clock, and both counts hold until the next request.
- R11: A `skip_req_i` that arrives while the sequencer is busy is ignored, and the counts and sequence carry on unchanged.
- R12: After a synchronous reset the outputs show the decode of an all-zero word (opcode 0, `mode_b_o`=13, `mode_a_o`=0, `len_o`=1, no literal), and the sequencer is idle with zero counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word0_i | input | 16 | Instruction word |
| word1_i | input | 16 | First following memory word |
| word2_i | input | 16 | Second following memory word |
| skip_req_i | input | 1 | Start a skip sequence |
| opcode_o | output | 5 | Decoded opcode |
| sel_b_o | output | 5 | Raw b selector |
| sel_a_o | output | 6 | Raw a selector |
| mode_b_o | output | 4 | Mode code of b |
| mode_a_o | output | 4 | Mode code of a |
| lit_o | output | 16 | Resolved short literal of a |
| lit_vld_o | output | 1 | a is a short literal |
| len_o | output | 2 | Instruction length in words |
| ext_b_o | output | 16 | Extra word owned by b |
| ext_a_o | output | 16 | Extra word owned by a |
| skip_busy_o | output | 1 | Skip sequence running |
| skip_done_o | output | 1 | One-clock pulse at the end of a skip |
| skip_words_o | output | 16 | Words skipped so far, and the offset of the next word to present |
| skip_cycles_o | output | 16 | Cycles spent skipping |

## Verification
The bench aims at the code 0x18, whose meaning depends on operand position. A design that ignored the position would report push for a or pop for b. It also tests both ends of the literal range: an off-by-one offset would give 0x0000 for code 0x20 instead of 0xffff. Instructions where both operands take extra words show whether a's word is taken from the right place, since a swapped selection puts `word1_i` on `ext_a_o`. Opcode zero with b codes in 0x10-0x1f shows whether the sub-opcode is wrongly counted in the length. Skip chains built of several conditionals in a row, with a second request arriving during the run, show a sequencer that stops after one instruction, miscounts cycles, or restarts, because any of these changes the final word and cycle totals.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int OPC_W  = 5;
  localparam int SELB_W = 5;
  localparam int SELA_W = 6;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_REG      = 4'd0,
    M_IND      = 4'd1,
    M_IND_OFS  = 4'd2,
    M_PUSH     = 4'd3,
    M_POP      = 4'd4,
    M_PEEK     = 4'd5,
    M_PICK     = 4'd6,
    M_SP       = 4'd7,
    M_PC       = 4'd8,
    M_EX       = 4'd9,
    M_NW_IND   = 4'd10,
    M_NW_LIT   = 4'd11,
    M_SLIT     = 4'd12,
    M_SUBOP    = 4'd13
  } opnd_mode_e;

  function automatic logic mode_takes_word(input logic [MODE_W-1:0] m);
    return (m == M_IND_OFS) || (m == M_NW_IND) || (m == M_NW_LIT);
  endfunction

endpackage

// File: rtl/opnd_classify.sv
module opnd_classify
  import insn_dec_pkg::*;
#(
  parameter bit IS_A = 1'b0
) (
  input  logic [SELA_W-1:0] code_i,
  output opnd_mode_e        mode_o,
  output logic              ext_o
);

  opnd_mode_e stack_mode;

  generate
    if (IS_A) begin : g_src
      assign stack_mode = M_POP;
    end else begin : g_dst
      assign stack_mode = M_PUSH;
    end
  endgenerate

  always_comb begin
    if (code_i[5]) begin
      mode_o = M_SLIT;
    end else if (code_i[4:3] == 2'b00) begin
      mode_o = M_REG;
    end else if (code_i[4:3] == 2'b01) begin
      mode_o = M_IND;
    end else if (code_i[4:3] == 2'b10) begin
      mode_o = M_IND_OFS;
    end else begin
      case (code_i[2:0])
        3'd0:    mode_o = stack_mode;
        3'd1:    mode_o = M_PEEK;
        3'd2:    mode_o = M_PICK;
        3'd3:    mode_o = M_SP;
        3'd4:    mode_o = M_PC;
        3'd5:    mode_o = M_EX;
        3'd6:    mode_o = M_NW_IND;
        default: mode_o = M_NW_LIT;
      endcase
    end
    ext_o = mode_takes_word(mode_o);
  end

endmodule

// File: rtl/insn_field_decode.sv
module insn_field_decode
  import insn_dec_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] w2_i,
  output logic [OPC_W-1:0]  opc_o,
  output logic [SELB_W-1:0] selb_o,
  output logic [SELA_W-1:0] sela_o,
  output opnd_mode_e        mode_b_o,
  output opnd_mode_e        mode_a_o,
  output logic [WORD_W-1:0] lit_o,
  output logic              lit_vld_o,
  output logic [1:0]        len_o,
  output logic [WORD_W-1:0] ext_b_o,
  output logic [WORD_W-1:0] ext_a_o,
  output logic              cond_o
);

  localparam int SELB_LSB = OPC_W;
  localparam int SELA_LSB = OPC_W + SELB_W;

  opnd_mode_e raw_mode_b;
  logic       raw_ext_b;
  logic       ext_b;
  logic       ext_a;
  logic       opc_zero;

  assign opc_o  = w0_i[SELB_LSB-1:0];
  assign selb_o = w0_i[SELA_LSB-1:SELB_LSB];
  assign sela_o = w0_i[SELA_LSB+SELA_W-1:SELA_LSB];
  assign opc_zero = (opc_o == '0);

  opnd_classify #(.IS_A(1'b0)) u_cls_b (
    .code_i ({1'b0, selb_o}),
    .mode_o (raw_mode_b),
    .ext_o  (raw_ext_b)
  );

  opnd_classify #(.IS_A(1'b1)) u_cls_a (
    .code_i (sela_o),
    .mode_o (mode_a_o),
    .ext_o  (ext_a)
  );

  always_comb begin
    mode_b_o  = opc_zero ? M_SUBOP : raw_mode_b;
    ext_b     = opc_zero ? 1'b0 : raw_ext_b;
    len_o     = 2'd1 + {1'b0, ext_b} + {1'b0, ext_a};
    ext_b_o   = ext_b ? w1_i : '0;
    ext_a_o   = ext_a ? (ext_b ? w2_i : w1_i) : '0;
    lit_vld_o = (mode_a_o == M_SLIT);
    lit_o     = lit_vld_o ? (WORD_W'(sela_o[4:0]) - WORD_W'(1)) : '0;
    cond_o    = (opc_o[4:3] == 2'b10);
  end

endmodule

// File: rtl/skip_seq.sv
module skip_seq #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [1:0]        cur_len_i,
  input  logic              cur_cond_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] words_o,
  output logic [CNT_W-1:0]  cycles_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      words_o  <= '0;
      cycles_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (req_i) begin
          busy_o   <= 1'b1;
          words_o  <= '0;
          cycles_o <= '0;
        end
      end else begin
        words_o  <= words_o + WORD_W'(cur_len_i);
        cycles_o <= cycles_o + CNT_W'(1);
        if (!cur_cond_i) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/insn_len_decode.sv
module insn_len_decode
  import insn_dec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word0_i,
  input  logic [WORD_W-1:0] word1_i,
  input  logic [WORD_W-1:0] word2_i,
  input  logic              skip_req_i,
  output logic [4:0]        opcode_o,
  output logic [4:0]        sel_b_o,
  output logic [5:0]        sel_a_o,
  output logic [3:0]        mode_b_o,
  output logic [3:0]        mode_a_o,
  output logic [WORD_W-1:0] lit_o,
  output logic              lit_vld_o,
  output logic [1:0]        len_o,
  output logic [WORD_W-1:0] ext_b_o,
  output logic [WORD_W-1:0] ext_a_o,
  output logic              skip_busy_o,
  output logic              skip_done_o,
  output logic [WORD_W-1:0] skip_words_o,
  output logic [CNT_W-1:0]  skip_cycles_o
);

  logic [OPC_W-1:0]  d_opc;
  logic [SELB_W-1:0] d_selb;
  logic [SELA_W-1:0] d_sela;
  opnd_mode_e        d_mode_b;
  opnd_mode_e        d_mode_a;
  logic [WORD_W-1:0] d_lit;
  logic              d_lit_vld;
  logic [1:0]        d_len;
  logic [WORD_W-1:0] d_ext_b;
  logic [WORD_W-1:0] d_ext_a;
  logic              d_cond;

  insn_field_decode #(.WORD_W(WORD_W)) u_dec (
    .w0_i      (word0_i),
    .w1_i      (word1_i),
    .w2_i      (word2_i),
    .opc_o     (d_opc),
    .selb_o    (d_selb),
    .sela_o    (d_sela),
    .mode_b_o  (d_mode_b),
    .mode_a_o  (d_mode_a),
    .lit_o     (d_lit),
    .lit_vld_o (d_lit_vld),
    .len_o     (d_len),
    .ext_b_o   (d_ext_b),
    .ext_a_o   (d_ext_a),
    .cond_o    (d_cond)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_o  <= '0;
      sel_b_o   <= '0;
      sel_a_o   <= '0;
      mode_b_o  <= M_SUBOP;
      mode_a_o  <= M_REG;
      lit_o     <= '0;
      lit_vld_o <= 1'b0;
      len_o     <= 2'd1;
      ext_b_o   <= '0;
      ext_a_o   <= '0;
    end else begin
      opcode_o  <= d_opc;
      sel_b_o   <= d_selb;
      sel_a_o   <= d_sela;
      mode_b_o  <= d_mode_b;
      mode_a_o  <= d_mode_a;
      lit_o     <= d_lit;
      lit_vld_o <= d_lit_vld;
      len_o     <= d_len;
      ext_b_o   <= d_ext_b;
      ext_a_o   <= d_ext_a;
    end
  end

  skip_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_skip (
    .clk        (clk),
    .rst        (rst),
    .req_i      (skip_req_i),
    .cur_len_i  (d_len),
    .cur_cond_i (d_cond),
    .busy_o     (skip_busy_o),
    .done_o     (skip_done_o),
    .words_o    (skip_words_o),
    .cycles_o   (skip_cycles_o)
  );

endmodule

// File: rtl/insn_len_decode_chk.sv
module insn_len_decode_chk
  import insn_dec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        opcode_o,
  input logic [5:0]        sel_a_o,
  input logic [3:0]        mode_b_o,
  input logic [3:0]        mode_a_o,
  input logic              lit_vld_o,
  input logic [1:0]        len_o,
  input logic [WORD_W-1:0] ext_b_o,
  input logic [WORD_W-1:0] ext_a_o,
  input logic              skip_busy_o,
  input logic              skip_done_o,
  input logic [WORD_W-1:0] skip_words_o,
  input logic [CNT_W-1:0]  skip_cycles_o
);

  p_len_sum_r6: assert property (@(posedge clk) disable iff (rst)
    len_o == 2'd1 + {1'b0, mode_takes_word(mode_b_o)} + {1'b0, mode_takes_word(mode_a_o)});

  p_subop_r8: assert property (@(posedge clk) disable iff (rst)
    (opcode_o == 5'd0) |-> (mode_b_o == M_SUBOP));

  p_lit_mode_r5: assert property (@(posedge clk) disable iff (rst)
    lit_vld_o |-> (mode_a_o == M_SLIT) && sel_a_o[5]);

  p_ext_b_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_takes_word(mode_b_o) |-> (ext_b_o == '0));

  p_ext_a_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_takes_word(mode_a_o) |-> (ext_a_o == '0));

  p_start_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(skip_busy_o) |-> (skip_words_o == '0) && (skip_cycles_o == '0));

  p_cycle_step_r9: assert property (@(posedge clk) disable iff (rst)
    (skip_busy_o && $past(skip_busy_o)) |-> (skip_cycles_o == $past(skip_cycles_o) + CNT_W'(1)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    skip_done_o |-> !skip_busy_o && $past(skip_busy_o));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!skip_busy_o && !$rose(skip_busy_o) && $past(!skip_busy_o)) |-> $stable(skip_words_o));

endmodule

bind insn_len_decode insn_len_decode_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .opcode_o      (opcode_o),
  .sel_a_o       (sel_a_o),
  .mode_b_o      (mode_b_o),
  .mode_a_o      (mode_a_o),
  .lit_vld_o     (lit_vld_o),
  .len_o         (len_o),
  .ext_b_o       (ext_b_o),
  .ext_a_o       (ext_a_o),
  .skip_busy_o   (skip_busy_o),
  .skip_done_o   (skip_done_o),
  .skip_words_o  (skip_words_o),
  .skip_cycles_o (skip_cycles_o)
);

// File: tb/insn_len_decode_bench.sv
module insn_len_decode_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] d0 = '0, d1 = '0, d2 = '0;
  logic        use_mem = 1'b0;
  logic [7:0]  sbase = '0;
  logic        skip_req = 1'b0;
  logic [15:0] mem [0:255];

  logic [15:0] word0, word1, word2;
  logic [4:0]  opcode_o, sel_b_o;
  logic [5:0]  sel_a_o;
  logic [3:0]  mode_b_o, mode_a_o;
  logic [15:0] lit_o, ext_b_o, ext_a_o, skip_words_o, skip_cycles_o;
  logic        lit_vld_o, skip_busy_o, skip_done_o;
  logic [1:0]  len_o;
  logic [7:0]  midx;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign midx  = sbase + skip_words_o[7:0];
  assign word0 = use_mem ? mem[midx] : d0;
  assign word1 = use_mem ? mem[8'(midx + 8'd1)] : d1;
  assign word2 = use_mem ? mem[8'(midx + 8'd2)] : d2;

  insn_len_decode u_insn_len_decode (
    .clk(clk), .rst(rst), .word0_i(word0), .word1_i(word1), .word2_i(word2),
    .skip_req_i(skip_req), .opcode_o(opcode_o), .sel_b_o(sel_b_o), .sel_a_o(sel_a_o),
    .mode_b_o(mode_b_o), .mode_a_o(mode_a_o), .lit_o(lit_o), .lit_vld_o(lit_vld_o),
    .len_o(len_o), .ext_b_o(ext_b_o), .ext_a_o(ext_a_o), .skip_busy_o(skip_busy_o),
    .skip_done_o(skip_done_o), .skip_words_o(skip_words_o), .skip_cycles_o(skip_cycles_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(input int code, input bit is_a, input bit opz);
    if (!is_a && opz) return 13;
    if (code < 8)  return 0;
    if (code < 16) return 1;
    if (code < 24) return 2;
    case (code)
      24: return is_a ? 4 : 3;
      25: return 5;
      26: return 6;
      27: return 7;
      28: return 8;
      29: return 9;
      30: return 10;
      31: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic bit exp_ext(input int m);
    return (m == 2) || (m == 10) || (m == 11);
  endfunction

  function automatic int exp_len(input logic [15:0] w);
    int mb, ma;
    mb = exp_mode(int'(w[9:5]), 1'b0, w[4:0] == 5'd0);
    ma = exp_mode(int'(w[15:10]), 1'b1, 1'b0);
    return 1 + int'(exp_ext(mb)) + int'(exp_ext(ma));
  endfunction

  function automatic string tag_of(input int code, input bit is_a, input bit opz);
    if (!is_a && opz) return "R8";
    if (code < 24) return "R2";
    if (code < 27) return "R3";
    if (code < 32) return "R4";
    return "R5";
  endfunction

  task automatic apply_dec(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
    int cb, ca, mb, ma, eb, ea;
    logic [15:0] xb, xa, lit;
    @(negedge clk);
    d0 = w0; d1 = w1; d2 = w2;
    @(negedge clk);
    cb = int'(w0[9:5]);
    ca = int'(w0[15:10]);
    mb = exp_mode(cb, 1'b0, w0[4:0] == 5'd0);
    ma = exp_mode(ca, 1'b1, 1'b0);
    eb = int'(exp_ext(mb));
    ea = int'(exp_ext(ma));
    xb = (eb != 0) ? w1 : 16'h0;
    xa = (ea != 0) ? ((eb != 0) ? w2 : w1) : 16'h0;
    lit = (ca >= 32) ? 16'(ca - 33) : 16'h0;
    chk({opcode_o, sel_b_o, sel_a_o} == {w0[4:0], w0[9:5], w0[15:10]}, "R1 fields",
        int'({sel_a_o, sel_b_o, opcode_o}), int'(w0));
    chk(int'(mode_b_o) == mb, {tag_of(cb, 1'b0, w0[4:0] == 5'd0), " mode_b"}, int'(mode_b_o), mb);
    chk(int'(mode_a_o) == ma, {tag_of(ca, 1'b1, 1'b0), " mode_a"}, int'(mode_a_o), ma);
    chk(lit_o == lit && lit_vld_o == (ca >= 32), "R5 literal", int'({lit_vld_o, lit_o}),
        int'({ca >= 32, lit}));
    chk(int'(len_o) == 1 + eb + ea, "R6 length", int'(len_o), 1 + eb + ea);
    chk(ext_b_o == xb && ext_a_o == xa, "R7 ext words", int'({ext_b_o, ext_a_o}), int'({xb, xa}));
  endtask

  task automatic run_skip(input logic [7:0] base, input bit extra_req);
    int words, cyc, nbusy;
    logic [7:0] a;
    logic [15:0] w;
    words = 0; cyc = 0; a = base;
    do begin
      w = mem[a];
      words += exp_len(w);
      cyc++;
      a = 8'(a + 8'(exp_len(w)));
    end while (w[4:3] == 2'b10 && cyc < 60);
    @(negedge clk);
    use_mem = 1'b1; sbase = base; skip_req = 1'b1;
    @(negedge clk);
    skip_req = 1'b0;
    chk(skip_busy_o && skip_words_o == 0 && skip_cycles_o == 0, "R9 start",
        int'({skip_busy_o, skip_words_o}), 32'h10000);
    nbusy = 0;
    while (skip_busy_o && nbusy < 100) begin
      skip_req = (extra_req && nbusy == 0);
      @(negedge clk);
      nbusy++;
    end
    skip_req = 1'b0;
    chk(int'(skip_words_o) == words, "R9 words", int'(skip_words_o), words);
    chk(int'(skip_cycles_o) == cyc, "R9 cycles", int'(skip_cycles_o), cyc);
    chk(nbusy == cyc, extra_req ? "R11 busy span" : "R10 busy span", nbusy, cyc);
    chk(skip_done_o && !skip_busy_o, "R10 done pulse", int'({skip_done_o, skip_busy_o}), 2);
    @(negedge clk);
    chk(!skip_done_o && int'(skip_words_o) == words && int'(skip_cycles_o) == cyc, "R10 hold",
        int'({skip_done_o, skip_words_o}), words);
    use_mem = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rw;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state visible before the first decode edge
    chk(opcode_o == 0 && mode_b_o == 13 && mode_a_o == 0 && len_o == 1 && !lit_vld_o
        && !skip_busy_o && skip_words_o == 0 && skip_cycles_o == 0, "R12 reset",
        int'({mode_b_o, mode_a_o, len_o}), int'({4'd13, 4'd0, 2'd1}));

    // directed: sweep a codes, sweep b codes, opcode zero, both extras
    for (int c = 0; c < 64; c++) apply_dec({6'(c), 5'd1, 5'd1}, 16'hA1A1, 16'hB2B2);
    for (int c = 0; c < 32; c++) apply_dec({6'h1f, 5'(c), 5'd2}, 16'h1234, 16'h5678);
    for (int c = 0; c < 32; c++) apply_dec({6'h1e, 5'(c), 5'd0}, 16'h0F0F, 16'hF0F0);
    apply_dec({6'h20, 5'h18, 5'h03}, 16'h1, 16'h2);
    apply_dec({6'h3f, 5'h18, 5'h03}, 16'h1, 16'h2);
    apply_dec(16'h0000, 16'hFFFF, 16'hFFFF);

    // random decode
    for (int i = 0; i < 400; i++) begin
      rw = 16'($urandom);
      apply_dec(rw, 16'($urandom), 16'($urandom));
    end

    // directed skip chain: two conditionals then a plain instruction
    mem[10] = {6'h1f, 5'd0, 5'h12};
    mem[12] = {6'h01, 5'h10, 5'h10};
    mem[14] = {6'h02, 5'h01, 5'h01};
    run_skip(8'd10, 1'b0);
    // single non-conditional skip, with a repeat request while busy
    mem[40] = {6'h1e, 5'h1f, 5'h03};
    run_skip(8'd40, 1'b1);
    // chain wrapping the bench memory end with an ignored repeat request
    mem[254] = {6'h00, 5'h02, 5'h17};
    mem[255] = {6'h22, 5'h1e, 5'h11};
    mem[1]   = {6'h05, 5'h03, 5'h04};
    run_skip(8'd254, 1'b1);

    // random skip chains
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 256; i++) begin
        rw = 16'($urandom);
        if (($urandom % 10) < 4) rw[4:0] = 5'h10 | 5'($urandom % 8);
        else rw[4:0] = 5'($urandom % 16);
        mem[i] = rw;
      end
      run_skip(8'($urandom), t[0]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule